// File: doc/BRIEF.md
# Floating-Point Status and Exception Controller

This block keeps the exception state of a floating-point unit. The datapath reports, one pulse per cycle, which exception conditions it hit. The block gathers these into sticky flags and folds them into an error-summary bit and a busy bit. It assembles a 16-bit status word from those flags, the condition codes and the current top-of-stack index. It also holds the writable fields of the 16-bit control word, including the per-exception masks and a global interrupt enable.

Results in the unit are reported after the instruction that caused them has moved on. For that reason, every recorded exception also captures the address of the faulting instruction and, when one is supplied, the address of its memory operand. The interrupt request is a pure function of the held flags, masks and enable. Software clears the flags with a single clear command. Computing the exceptions is the job of the datapath and is not part of this block.

All state updates take effect on the clock edge that samples the input. The outputs show the new value from the following cycle.

Top module: `fpx_status_ctl`

## Requirements
- R1: While reset is asserted and right after it, the status word reads 0x0000, the control word reads 0x037F, the interrupt request is 0 and both captured pointers are 0.
- R2: A pulse on bit k of `exc_evt_i` sets status bit k on the next cycle. The bit positions are precision 5, underflow 4, overflow 3, zero-divide 2, denormal 1 and invalid 0. A set flag stays set until a clear command.
- R3: `clr_exc_i` zeroes status bits 6..0 on the next cycle, which also drops bits 7 and 15. An event in the same cycle still sets its own flag. The clear leaves the condition codes and the top-of-stack field unchanged.
- R4: Status bit 7 is the OR of status bits 5..0, and status bit 15 always equals bit 7.
- R5: A pulse on `stk_fault_i` sets status bit 6 and status bit 0. It also writes status bit 9 with `stk_ovf_i` (1 for overflow, 0 for underflow), and this overrides a condition-code write in the same cycle.
- R6: `cc_we_i` loads `cc_i[3]` into status bit 14, and `cc_i[2]`, `cc_i[1]` and `cc_i[0]` into bits 10, 9 and 8. Without a write, these bits hold.
- R7: Status bits 13..11 show the value that `top_i` had one cycle earlier.
- R8: `cw_we_i` stores bits 11..7 and 5..0 of `cw_wdata_i`. Control bit 6 always reads 1 and bits 15..12 always read 0. Bit 7 is the interrupt enable, and bits 5..0 mask the flags with the same position.
- R9: `irq_o` is 1 exactly when control bit 7 is set and some status bit k in 5..0 is set while control bit k is clear.
- R10: Any event (`exc_evt_i` nonzero or `stk_fault_i`) loads `ins_addr_i` into `ins_ptr_o`. In the same cycle `opnd_ptr_o` loads `opnd_addr_i` if `opnd_vld_i` is 1 and 0 if it is not. Without an event both pointers hold, and the clear command does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_evt_i | input | 6 | Per-cycle exception event pulses |
| stk_fault_i | input | 1 | Stack fault event pulse |
| stk_ovf_i | input | 1 | With a stack fault: 1 overflow, 0 underflow |
| cc_we_i | input | 1 | Condition-code write strobe |
| cc_i | input | 4 | Condition codes {C3,C2,C1,C0} |
| top_i | input | 3 | Current top-of-stack register index |
| cw_we_i | input | 1 | Control word write strobe |
| cw_wdata_i | input | 16 | Control word write data |
| clr_exc_i | input | 1 | Clear-exceptions command |
| ins_addr_i | input | AW | Address of the instruction now executing |
| opnd_addr_i | input | AW | Address of its memory operand |
| opnd_vld_i | input | 1 | The operand address is meaningful |
| status_o | output | 16 | Status word |
| control_o | output | 16 | Control word |
| irq_o | output | 1 | Unmasked exception pending request |
| ins_ptr_o | output | AW | Captured faulting instruction address |
| opnd_ptr_o | output | AW | Captured faulting operand address |

## Verification
The bench targets several corner cases.
- A clear arriving in the same cycle as a new event: a design that lets the clear win would lose the new flag.
- A stack fault coinciding with a condition-code write: the wrong priority leaves the overflow indicator at the written value.
- A flag that is set but masked, or unmasked with the global enable off: a design that drops the mask or the enable would raise a false request.
- An event that arrives without an operand address, followed by a clear: a faulty capture path would keep a stale operand or lose the instruction address.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NFLAG     = 6;
  localparam int CCW       = 4;
  localparam int TOPW      = 3;
  localparam int WORDW     = 16;
  localparam int FLAG_INV  = 0;
  localparam int SW_SFLT   = 6;
  localparam int SW_ES     = 7;
  localparam int SW_C0     = 8;
  localparam int SW_C1     = 9;
  localparam int SW_C2     = 10;
  localparam int SW_TOP_LO = 11;
  localparam int SW_C3     = 14;
  localparam int SW_BUSY   = 15;
  localparam int CW_IE     = 7;
  localparam logic [WORDW-1:0] CW_RESET   = 16'h037F;
  localparam logic [WORDW-1:0] CW_WR_MASK = 16'h0FBF;
  localparam logic [WORDW-1:0] CW_ONES    = 16'h0040;
endpackage

// File: rtl/fpx_rst_sync.sv
module fpx_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_no = s2_q;
endmodule

// File: rtl/fpx_flag_acc.sv
module fpx_flag_acc
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] evt_i,
  input  logic             stk_fault_i,
  input  logic             stk_ovf_i,
  input  logic             clr_i,
  input  logic             cc_we_i,
  input  logic [CCW-1:0]   cc_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             sflt_o,
  output logic [CCW-1:0]   cc_o
);
  logic [NFLAG-1:0] flags_q, flags_d, evt_all;
  logic             sflt_q, sflt_d;
  logic [CCW-1:0]   cc_q, cc_d;

  // A stack fault also raises the invalid-operation flag
  always_comb begin
    evt_all = evt_i;
    evt_all[FLAG_INV] = evt_i[FLAG_INV] | stk_fault_i;
  end

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    always_comb begin
      flags_d[k] = flags_q[k];
      if (clr_i) flags_d[k] = 1'b0;
      if (evt_all[k]) flags_d[k] = 1'b1;
    end
  end

  always_comb begin
    sflt_d = sflt_q;
    if (clr_i) sflt_d = 1'b0;
    if (stk_fault_i) sflt_d = 1'b1;
  end

  // Condition codes {C3,C2,C1,C0}; stack fault owns C1
  always_comb begin
    cc_d = cc_q;
    if (cc_we_i) cc_d = cc_i;
    if (stk_fault_i) cc_d[1] = stk_ovf_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      sflt_q  <= 1'b0;
      cc_q    <= '0;
    end else begin
      flags_q <= flags_d;
      sflt_q  <= sflt_d;
      cc_q    <= cc_d;
    end
  end

  assign flags_o = flags_q;
  assign sflt_o  = sflt_q;
  assign cc_o    = cc_q;

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(|evt_i) && !stk_fault_i) |=> (flags_q == '0 && !sflt_q));

  assert_stack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stk_fault_i |=> (sflt_q && flags_q[FLAG_INV] && cc_q[1] == $past(stk_ovf_i)));

  assert_cc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cc_we_i && !stk_fault_i) |=> $stable(cc_q));
endmodule

// File: rtl/fpx_ctrl_reg.sv
module fpx_ctrl_reg
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [WORDW-1:0] wdata_i,
  output logic [WORDW-1:0] cw_o
);
  logic [WORDW-1:0] cw_q, cw_d;

  always_comb begin
    cw_d = cw_q;
    if (we_i) cw_d = (wdata_i & CW_WR_MASK) | CW_ONES;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cw_q <= CW_RESET;
    else        cw_q <= cw_d;
  end

  assign cw_o = cw_q;

  assert_cw_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (cw_q[5:0] == $past(wdata_i[5:0]) && cw_q[11:7] == $past(wdata_i[11:7])));

  assert_cw_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cw_q[6] && cw_q[15:12] == 4'h0));
endmodule

// File: rtl/fpx_ptr_latch.sv
module fpx_ptr_latch #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic [AW-1:0] ins_addr_i,
  input  logic [AW-1:0] opnd_addr_i,
  input  logic          opnd_vld_i,
  output logic [AW-1:0] ins_ptr_o,
  output logic [AW-1:0] opnd_ptr_o
);
  logic [AW-1:0] ins_q, ins_d, opnd_q, opnd_d;

  always_comb begin
    ins_d  = ins_q;
    opnd_d = opnd_q;
    if (cap_i) begin
      ins_d  = ins_addr_i;
      opnd_d = opnd_vld_i ? opnd_addr_i : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q  <= '0;
      opnd_q <= '0;
    end else begin
      ins_q  <= ins_d;
      opnd_q <= opnd_d;
    end
  end

  assign ins_ptr_o  = ins_q;
  assign opnd_ptr_o = opnd_q;

  assert_ptr_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (ins_q == $past(ins_addr_i)));

  assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> ($stable(ins_q) && $stable(opnd_q)));
endmodule

// File: rtl/fpx_status_ctl.sv
module fpx_status_ctl
  import fpx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       exc_evt_i,
  input  logic             stk_fault_i,
  input  logic             stk_ovf_i,
  input  logic             cc_we_i,
  input  logic [3:0]       cc_i,
  input  logic [2:0]       top_i,
  input  logic             cw_we_i,
  input  logic [15:0]      cw_wdata_i,
  input  logic             clr_exc_i,
  input  logic [AW-1:0]    ins_addr_i,
  input  logic [AW-1:0]    opnd_addr_i,
  input  logic             opnd_vld_i,
  output logic [15:0]      status_o,
  output logic [15:0]      control_o,
  output logic             irq_o,
  output logic [AW-1:0]    ins_ptr_o,
  output logic [AW-1:0]    opnd_ptr_o
);
  logic             rst_ns;
  logic [NFLAG-1:0] flags;
  logic             sflt;
  logic [CCW-1:0]   cc;
  logic [TOPW-1:0]  top_q, top_d;
  logic [WORDW-1:0] cw;
  logic             err_sum;
  logic             any_evt;

  fpx_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_ns)
  );

  fpx_flag_acc u_flags (
    .clk         (clk),
    .rst_n       (rst_ns),
    .evt_i       (exc_evt_i),
    .stk_fault_i (stk_fault_i),
    .stk_ovf_i   (stk_ovf_i),
    .clr_i       (clr_exc_i),
    .cc_we_i     (cc_we_i),
    .cc_i        (cc_i),
    .flags_o     (flags),
    .sflt_o      (sflt),
    .cc_o        (cc)
  );

  fpx_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_ns),
    .we_i    (cw_we_i),
    .wdata_i (cw_wdata_i),
    .cw_o    (cw)
  );

  assign any_evt = (|exc_evt_i) | stk_fault_i;

  fpx_ptr_latch #(.AW(AW)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_ns),
    .cap_i       (any_evt),
    .ins_addr_i  (ins_addr_i),
    .opnd_addr_i (opnd_addr_i),
    .opnd_vld_i  (opnd_vld_i),
    .ins_ptr_o   (ins_ptr_o),
    .opnd_ptr_o  (opnd_ptr_o)
  );

  assign top_d = top_i;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) top_q <= '0;
    else         top_q <= top_d;
  end

  assign err_sum = |flags;

  always_comb begin
    status_o = '0;
    status_o[NFLAG-1:0]                = flags;
    status_o[SW_SFLT]                  = sflt;
    status_o[SW_ES]                    = err_sum;
    status_o[SW_C0]                    = cc[0];
    status_o[SW_C1]                    = cc[1];
    status_o[SW_C2]                    = cc[2];
    status_o[SW_TOP_LO +: TOPW]        = top_q;
    status_o[SW_C3]                    = cc[3];
    status_o[SW_BUSY]                  = err_sum;
  end

  assign control_o = cw;
  assign irq_o     = cw[CW_IE] & (|(flags & ~cw[NFLAG-1:0]));

  assert_top_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    1'b1 |=> (status_o[13:11] == $past(top_i)));

  assert_irq_enable_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    irq_o |-> (control_o[7] && status_o[7]));

  assert_busy_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    (status_o[15] != status_o[7]) |-> 1'b0);
endmodule

// File: tb/fpx_status_ctl_tb.sv
module fpx_status_ctl_tb;
  localparam int AW = 32;
  localparam int NV = 10;
  // {exc6, stk, ovf, clr, ccwe, cc4, top3, cwwe, cw16, exp_sw16, exp_cw16, exp_irq}
  localparam logic [66:0] VEC [NV] = '{
    {6'h00,1'b0,1'b0,1'b0,1'b0,4'h0,3'd5,1'b0,16'h0000,16'h2800,16'h037F,1'b0},
    {6'h04,1'b0,1'b0,1'b0,1'b0,4'h0,3'd5,1'b0,16'h0000,16'hA884,16'h037F,1'b0},
    {6'h00,1'b0,1'b0,1'b0,1'b0,4'h0,3'd5,1'b1,16'h00FB,16'hA884,16'h00FB,1'b1},
    {6'h00,1'b0,1'b0,1'b0,1'b1,4'hA,3'd3,1'b0,16'h0000,16'hDA84,16'h00FB,1'b1},
    {6'h00,1'b0,1'b0,1'b1,1'b0,4'h0,3'd3,1'b0,16'h0000,16'h5A00,16'h00FB,1'b0},
    {6'h00,1'b1,1'b0,1'b0,1'b0,4'h0,3'd4,1'b0,16'h0000,16'hE0C1,16'h00FB,1'b0},
    {6'h20,1'b0,1'b0,1'b1,1'b0,4'h0,3'd4,1'b0,16'h0000,16'hE0A0,16'h00FB,1'b0},
    {6'h00,1'b1,1'b1,1'b0,1'b1,4'h0,3'd7,1'b0,16'h0000,16'hBAE1,16'h00FB,1'b0},
    {6'h00,1'b0,1'b0,1'b0,1'b0,4'h0,3'd7,1'b1,16'h0000,16'hBAE1,16'h0040,1'b0},
    {6'h00,1'b0,1'b0,1'b0,1'b0,4'h0,3'd7,1'b1,16'h1CBE,16'hBAE1,16'h0CFE,1'b1}
  };
  localparam string VTAG [NV] = '{"R7", "R2", "R9", "R6", "R3", "R5", "R3", "R5", "R8", "R9"};

  logic          clk = 1'b0;
  logic          rst_n;
  logic [5:0]    exc_evt;
  logic          stk_fault, stk_ovf, cc_we, cw_we, clr_exc, opnd_vld;
  logic [3:0]    cc;
  logic [2:0]    top;
  logic [15:0]   cw_wdata;
  logic [AW-1:0] ins_addr, opnd_addr;
  logic [15:0]   status, control;
  logic          irq;
  logic [AW-1:0] ins_ptr, opnd_ptr;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  fpx_status_ctl #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .exc_evt_i(exc_evt), .stk_fault_i(stk_fault),
    .stk_ovf_i(stk_ovf), .cc_we_i(cc_we), .cc_i(cc), .top_i(top),
    .cw_we_i(cw_we), .cw_wdata_i(cw_wdata), .clr_exc_i(clr_exc),
    .ins_addr_i(ins_addr), .opnd_addr_i(opnd_addr), .opnd_vld_i(opnd_vld),
    .status_o(status), .control_o(control), .irq_o(irq),
    .ins_ptr_o(ins_ptr), .opnd_ptr_o(opnd_ptr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    exc_evt = '0; stk_fault = 0; stk_ovf = 0; cc_we = 0; cc = '0;
    cw_we = 0; cw_wdata = '0; clr_exc = 0; opnd_vld = 0;
    ins_addr = '0; opnd_addr = '0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk_reset(input string when);
    chk({"R1 status ", when}, 64'(status), 64'h0);
    chk({"R1 control ", when}, 64'(control), 64'h037F);
    chk({"R1 irq ", when}, 64'(irq), 64'h0);
    chk({"R1 ins_ptr ", when}, 64'(ins_ptr), 64'h0);
    chk({"R1 opnd_ptr ", when}, 64'(opnd_ptr), 64'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 0; top = 3'd0; idle();
    repeat (3) @(negedge clk);
    chk_reset("in reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_reset("after release");

    for (int i = 0; i < NV; i++) begin
      exc_evt   = VEC[i][66:61];
      stk_fault = VEC[i][60];
      stk_ovf   = VEC[i][59];
      clr_exc   = VEC[i][58];
      cc_we     = VEC[i][57];
      cc        = VEC[i][56:53];
      top       = VEC[i][52:50];
      cw_we     = VEC[i][49];
      cw_wdata  = VEC[i][48:33];
      @(negedge clk);
      idle();
      chk({VTAG[i], " status"},  64'(status),  64'(VEC[i][32:17]));
      chk({VTAG[i], " control"}, 64'(control), 64'(VEC[i][16:1]));
      chk({VTAG[i], " irq"},     64'(irq),     64'(VEC[i][0]));
    end

    // R10 capture with operand
    exc_evt = 6'h08; ins_addr = 32'h1000_0040; opnd_addr = 32'h2000_0080; opnd_vld = 1;
    @(negedge clk); idle();
    chk("R10 ins load", 64'(ins_ptr), 64'h1000_0040);
    chk("R10 opnd load", 64'(opnd_ptr), 64'h2000_0080);
    // R10 no event: hold
    ins_addr = 32'h0000_DEAD; opnd_addr = 32'h0000_BEEF; opnd_vld = 1;
    @(negedge clk); idle();
    chk("R10 ins hold", 64'(ins_ptr), 64'h1000_0040);
    chk("R10 opnd hold", 64'(opnd_ptr), 64'h2000_0080);
    // R10 stack fault without operand
    stk_fault = 1; stk_ovf = 1; ins_addr = 32'h1000_0044; opnd_addr = 32'h0000_0777;
    @(negedge clk); idle();
    chk("R10 ins on stack fault", 64'(ins_ptr), 64'h1000_0044);
    chk("R10 opnd zero when absent", 64'(opnd_ptr), 64'h0);
    // R3 clear: flags drop, C1 and TOP stay, pointers untouched
    clr_exc = 1;
    @(negedge clk); idle();
    chk("R3 clear status", 64'(status), 64'h3A00);
    chk("R3 clear irq", 64'(irq), 64'h0);
    chk("R10 ptr after clear", 64'(ins_ptr), 64'h1000_0044);
    // R9 masked flag raises no request; R4 summary and busy follow it
    exc_evt = 6'h02;
    @(negedge clk); idle();
    chk("R4 status with D flag", 64'(status), 64'hBA82);
    chk("R9 masked no irq", 64'(irq), 64'h0);
    // R1 mid-run reset
    rst_n = 0;
    #1;
    chk_reset("mid-run");
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R7 top after reset", 64'(status[13:11]), 64'd7);
    finish_up();
  end
endmodule